// File: doc/BRIEF.md
# Auto-Retry Transmit Sequencer

This block runs one acknowledged-transmit transaction for a packet radio link layer. The host programs two retry limits and an acknowledgement window length, then pulses a start input together with a flag saying whether the outgoing frame asks for an acknowledgement. The sequencer asks an external channel-access unit for a clear channel, repeating on a busy result up to the channel-access limit. Once the channel is clear it starts the transmitter. When the frame asks for an acknowledgement, it turns the receiver on for a bounded window after the send. It resends the frame after a fresh channel-access step each time the window closes empty, until the frame retry limit is used up.

When the transaction finishes, a sticky interrupt flag is set and a 3-bit completion code is published. The interrupt output follows the flag only while the mask input is high, and the host clears the flag by writing 1. If the channel-access limit is set to its all-ones value (7), channel access is skipped, the frame retry limit is ignored and exactly one send is made. This supports slotted acknowledgement timing.

Top module: `arq_tx_sequencer`

## Requirements
- R1: `busy` is 0 after reset and while idle. It reads 1 from the cycle after an accepted `start` until the cycle after the transaction completes.
- R2: `status` reads 7 (in progress) after reset and from the cycle after an accepted `start` until completion. At completion it takes one of 0, 1, 3 or 5.
- R3: When `ack_request` was 0 at start, the transaction completes in the cycle after `tx_done` with `status` 0 (success), and `rx_on` is never asserted.
- R4: When `ack_request` was 1, `rx_on` rises in the cycle after `tx_done`. An `ack_rcvd` pulse while `rx_on` is high completes the transaction with `status` 1 if `ack_pending` is 1, and 0 otherwise.
- R5: The receive window lasts `cfg_ack_window` cycles. If it closes with no acknowledgement, a new channel-access step and send follow. After `cfg_frame_retries`+1 sends with no acknowledgement, the transaction completes with `status` 5 (no acknowledgement).
- R6: With `cfg_cca_retries` = 7, `cca_req` never asserts. A one-cycle `tx_start` pulse appears in the cycle after `start`, and exactly one send is made whatever `cfg_frame_retries` holds.
- R7: Each channel-access step allows `cfg_cca_retries`+1 attempts. When all of them return busy (`cca_done` with `cca_clear` = 0), the transaction completes with `status` 3 (channel access failure) and that step sends nothing.
- R8: Completion sets an interrupt flag that stays set until `irq_clear` is 1. `irq` equals the flag ANDed with `irq_mask`.
- R9: A `start` pulse while `busy` is 1 is ignored: the number of channel-access attempts, sends and receive windows is unchanged.
- R10: An `ack_rcvd` pulse while `rx_on` is 0 has no effect. An acknowledgement in the last cycle of the window is accepted as success.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_cca_retries | input | CCA_W | Channel-access retry limit; all ones bypasses channel access |
| cfg_frame_retries | input | FRM_W | Frame retry limit |
| cfg_ack_window | input | WIN_W | Acknowledgement window length in cycles |
| start | input | 1 | Start pulse for a transaction |
| ack_request | input | 1 | Frame asks for an acknowledgement (sampled with start) |
| cca_req | output | 1 | Channel-access request, held during the access step |
| cca_done | input | 1 | Channel-access attempt finished |
| cca_clear | input | 1 | With cca_done: 1 = channel clear, 0 = busy |
| tx_start | output | 1 | One-cycle pulse starting a frame send |
| tx_done | input | 1 | Frame send finished |
| rx_on | output | 1 | Receiver on, waiting for an acknowledgement |
| ack_rcvd | input | 1 | Acknowledgement frame received pulse |
| ack_pending | input | 1 | Frame-pending bit of the received acknowledgement |
| busy | output | 1 | Transaction in progress |
| status | output | 3 | Completion code: 0 ok, 1 ok with pending data, 3 access failure, 5 no ack, 7 in progress |
| irq_mask | input | 1 | Interrupt enable |
| irq_clear | input | 1 | Write 1 to clear the interrupt flag |
| irq | output | 1 | Transmit-end interrupt |

## Verification
The bench sweeps every channel-access limit from 0 to 7 against frame limits 0 to 3. Each pair runs with three busy-result plans: always clear at first try, clear on the last allowed try, and never clear. These separate the off-by-one at the access limit from the failure exit. Each case runs with and without an acknowledgement request, and the acknowledgement arrives on the first send, on the final send, or never. The arrival point moves across the window up to its last cycle, which distinguishes success, pending-data success, retry counting and the no-acknowledgement exit. Send, access and window counts are compared with values worked out arithmetically. Directed cases cover a start during busy, a stray acknowledgement while idle, and masking of the interrupt.

// File: rtl/arq_tx_pkg.sv
`timescale 1ns/1ps
package arq_tx_pkg;
   typedef enum logic [2:0] {
      TXN_OK        = 3'd0,
      TXN_OK_PEND   = 3'd1,
      TXN_CHAN_BUSY = 3'd3,
      TXN_NO_ACK    = 3'd5,
      TXN_RUNNING   = 3'd7
   } txn_code_e;

   typedef enum logic [1:0] {
      PH_IDLE   = 2'd0,
      PH_ACCESS = 2'd1,
      PH_SEND   = 2'd2,
      PH_LISTEN = 2'd3
   } txn_phase_e;
endpackage

// File: rtl/arq_step_ctr.sv
`timescale 1ns/1ps
module arq_step_ctr #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         inc,
   input  logic [W-1:0] limit,
   output logic         at_limit
);
   logic [W-1:0] cnt_q;

   generate
      if (W < 1) begin : g_bad_width
         $error("arq_step_ctr: W must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)      cnt_q <= '0;
      else if (clr)    cnt_q <= '0;
      else if (inc)    cnt_q <= cnt_q + 1'b1;
   end

   assign at_limit = (cnt_q == limit);

   // R5 / R7: the sequencer never asks for another retry once the limit is reached
   a_r7_step_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !clr) |-> !at_limit);
endmodule

// File: rtl/arq_win_timer.sv
`timescale 1ns/1ps
module arq_win_timer #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         run,
   input  logic [W-1:0] len,
   output logic         expired
);
   logic [W-1:0] cnt_q;
   logic [W:0]   nxt;

   generate
      if (W < 1) begin : g_bad_width
         $error("arq_win_timer: W must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)    cnt_q <= '0;
      else if (!run) cnt_q <= '0;
      else           cnt_q <= cnt_q + 1'b1;
   end

   assign nxt     = {1'b0, cnt_q} + 1'b1;
   assign expired = run && (nxt >= {1'b0, len});

   // R5: the window owner leaves the listening phase no later than the last window cycle
   a_r5_window_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      (run && len != '0) |-> ({1'b0, cnt_q} < {1'b0, len}));
endmodule

// File: rtl/arq_irq_latch.sv
`timescale 1ns/1ps
module arq_irq_latch #(
   parameter bit SET_WINS = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   input  logic mask,
   output logic irq
);
   logic flag_q;

   generate
      if (SET_WINS) begin : g_set_first
         always_ff @(posedge clk) begin
            if (!rst_n)   flag_q <= 1'b0;
            else if (set) flag_q <= 1'b1;
            else if (clr) flag_q <= 1'b0;
         end
      end else begin : g_clr_first
         always_ff @(posedge clk) begin
            if (!rst_n)   flag_q <= 1'b0;
            else if (clr) flag_q <= 1'b0;
            else if (set) flag_q <= 1'b1;
         end
      end
   endgenerate

   assign irq = flag_q & mask;

   // R8: flag is sticky until cleared, set by completion, dropped by a clear
   a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q && !clr) |=> flag_q);
   a_r8_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
      (set && (SET_WINS || !clr)) |=> flag_q);
   a_r8_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !set) |=> !flag_q);
endmodule

// File: rtl/arq_tx_sequencer.sv
`timescale 1ns/1ps
module arq_tx_sequencer
   import arq_tx_pkg::*;
#(
   parameter int CCA_W = 3,
   parameter int FRM_W = 4,
   parameter int WIN_W = 8,
   parameter bit IRQ_SET_WINS = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CCA_W-1:0] cfg_cca_retries,
   input  logic [FRM_W-1:0] cfg_frame_retries,
   input  logic [WIN_W-1:0] cfg_ack_window,
   input  logic             start,
   input  logic             ack_request,
   output logic             cca_req,
   input  logic             cca_done,
   input  logic             cca_clear,
   output logic             tx_start,
   input  logic             tx_done,
   output logic             rx_on,
   input  logic             ack_rcvd,
   input  logic             ack_pending,
   output logic             busy,
   output logic [2:0]       status,
   input  logic             irq_mask,
   input  logic             irq_clear,
   output logic             irq
);
   localparam logic [CCA_W-1:0] BYPASS_CODE = {CCA_W{1'b1}};

   generate
      if (CCA_W < 1 || FRM_W < 1 || WIN_W < 1) begin : g_bad_cfg
         $error("arq_tx_sequencer: all widths must be at least 1");
      end
   endgenerate

   txn_phase_e ph_q, ph_n;
   txn_code_e  code_q, fin_code;
   logic       ackreq_q, bypass_q, txs_q;
   logic       accept, fin, go_access, go_send, cca_inc, frm_inc;
   logic       cca_at_lim, frm_at_lim, win_exp;
   logic       bypass_now;

   assign bypass_now = (cfg_cca_retries == BYPASS_CODE);
   assign accept     = (ph_q == PH_IDLE) && start;

   arq_step_ctr #(.W(CCA_W)) u_cca_ctr (
      .clk(clk), .rst_n(rst_n), .clr(go_access), .inc(cca_inc),
      .limit(cfg_cca_retries), .at_limit(cca_at_lim));

   arq_step_ctr #(.W(FRM_W)) u_frm_ctr (
      .clk(clk), .rst_n(rst_n), .clr(accept), .inc(frm_inc),
      .limit(cfg_frame_retries), .at_limit(frm_at_lim));

   arq_win_timer #(.W(WIN_W)) u_win (
      .clk(clk), .rst_n(rst_n), .run(ph_q == PH_LISTEN),
      .len(cfg_ack_window), .expired(win_exp));

   arq_irq_latch #(.SET_WINS(IRQ_SET_WINS)) u_irq (
      .clk(clk), .rst_n(rst_n), .set(fin), .clr(irq_clear),
      .mask(irq_mask), .irq(irq));

   always_comb begin
      ph_n      = ph_q;
      fin       = 1'b0;
      fin_code  = TXN_OK;
      go_access = 1'b0;
      go_send   = 1'b0;
      cca_inc   = 1'b0;
      frm_inc   = 1'b0;
      case (ph_q)
         PH_IDLE: begin
            if (start) begin
               if (bypass_now) begin go_send = 1'b1; ph_n = PH_SEND; end
               else begin go_access = 1'b1; ph_n = PH_ACCESS; end
            end
         end
         PH_ACCESS: begin
            if (cca_done) begin
               if (cca_clear) begin
                  go_send = 1'b1; ph_n = PH_SEND;
               end else if (cca_at_lim) begin
                  fin = 1'b1; fin_code = TXN_CHAN_BUSY; ph_n = PH_IDLE;
               end else begin
                  cca_inc = 1'b1;
               end
            end
         end
         PH_SEND: begin
            if (tx_done) begin
               if (ackreq_q) ph_n = PH_LISTEN;
               else begin fin = 1'b1; fin_code = TXN_OK; ph_n = PH_IDLE; end
            end
         end
         PH_LISTEN: begin
            if (ack_rcvd) begin
               fin = 1'b1; ph_n = PH_IDLE;
               fin_code = ack_pending ? TXN_OK_PEND : TXN_OK;
            end else if (win_exp) begin
               if (bypass_q || frm_at_lim) begin
                  fin = 1'b1; fin_code = TXN_NO_ACK; ph_n = PH_IDLE;
               end else begin
                  frm_inc = 1'b1; go_access = 1'b1; ph_n = PH_ACCESS;
               end
            end
         end
         default: ph_n = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ph_q     <= PH_IDLE;
         code_q   <= TXN_RUNNING;
         ackreq_q <= 1'b0;
         bypass_q <= 1'b0;
         txs_q    <= 1'b0;
      end else begin
         ph_q  <= ph_n;
         txs_q <= go_send;
         if (accept) begin
            code_q   <= TXN_RUNNING;
            ackreq_q <= ack_request;
            bypass_q <= bypass_now;
         end else if (fin) begin
            code_q <= fin_code;
         end
      end
   end

   assign busy     = (ph_q != PH_IDLE);
   assign cca_req  = (ph_q == PH_ACCESS);
   assign rx_on    = (ph_q == PH_LISTEN);
   assign tx_start = txs_q;
   assign status   = code_q;

   a_r1_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy);
   a_r2_busy_running: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (status == 3'd7));
   a_r2_end_coded: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (status != 3'd7));
   a_r3_noack_finish: assert property (@(posedge clk) disable iff (!rst_n)
      (ph_q == PH_SEND && tx_done && !ackreq_q) |=> (!busy && status == 3'd0));
   a_r4_listen_after_send: assert property (@(posedge clk) disable iff (!rst_n)
      (ph_q == PH_SEND && tx_done && ackreq_q) |=> rx_on);
   a_r6_bypass_no_access: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && bypass_q) |-> !cca_req);
   a_r6_send_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      tx_start |=> !tx_start);
   a_r10_stray_ack: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start && ack_rcvd) |=> ($stable(status) && !busy));
endmodule

// File: tb/arq_tx_sequencer_tb.sv
`timescale 1ns/1ps
module arq_tx_sequencer_tb;
   localparam int CW = 3, FW = 4, TW = 8, WIN = 4;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic          rst_n = 1'b0;
   logic [CW-1:0] cfg_cca_retries = '0;
   logic [FW-1:0] cfg_frame_retries = '0;
   logic [TW-1:0] cfg_ack_window = TW'(WIN);
   logic start = 1'b0, ack_request = 1'b0;
   logic cca_req, cca_done, cca_clear, tx_start, tx_done, rx_on;
   logic ack_rcvd, ack_pending, busy, irq;
   logic [2:0] status;
   logic irq_mask = 1'b1, irq_clear = 1'b0;

   arq_tx_sequencer #(.CCA_W(CW), .FRM_W(FW), .WIN_W(TW)) u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_cca_retries(cfg_cca_retries),
      .cfg_frame_retries(cfg_frame_retries), .cfg_ack_window(cfg_ack_window),
      .start(start), .ack_request(ack_request), .cca_req(cca_req),
      .cca_done(cca_done), .cca_clear(cca_clear), .tx_start(tx_start),
      .tx_done(tx_done), .rx_on(rx_on), .ack_rcvd(ack_rcvd),
      .ack_pending(ack_pending), .busy(busy), .status(status),
      .irq_mask(irq_mask), .irq_clear(irq_clear), .irq(irq));

   int n_chk = 0, n_fail = 0, cycles = 0;

   task automatic chk(string req, string what, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // environment model: responds to the sequencer at falling edges
   int env_fail_n = 0, env_ack_on = 0, env_ack_dly = 0;
   bit env_pend = 0, env_stray = 0;
   int n_cca = 0, n_tx = 0, n_win = 0, step_fails = 0, widx = 0;
   bit pend_tx = 0, prev_rx = 0;

   initial begin
      cca_done = 0; cca_clear = 0; tx_done = 0; ack_rcvd = 0; ack_pending = 0;
   end

   always @(negedge clk) begin
      cca_done = 0; cca_clear = 0; tx_done = 0; ack_rcvd = 0; ack_pending = 0;
      if (cca_req) begin
         n_cca++;
         cca_done = 1;
         if (step_fails >= env_fail_n) cca_clear = 1;
         else step_fails++;
      end else step_fails = 0;
      if (pend_tx) begin tx_done = 1; pend_tx = 0; end
      if (tx_start) begin n_tx++; pend_tx = 1; end
      if (rx_on) begin
         if (!prev_rx) begin n_win++; widx = 0; end
         else widx++;
         if (n_tx == env_ack_on && widx == env_ack_dly) begin
            ack_rcvd = 1; ack_pending = env_pend;
         end
      end
      prev_rx = rx_on;
      if (env_stray) begin ack_rcvd = 1; ack_pending = 1; env_stray = 0; end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 190000) begin
         n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   task automatic run_txn(int l, int f, int fplan, bit ar, int a, int d, bit pend,
                          bit mid_start, bit do_clear);
      int cyc, e_cca, e_tx, e_win, e_st;
      string rq;
      @(negedge clk);
      cfg_cca_retries = CW'(l); cfg_frame_retries = FW'(f);
      env_fail_n = fplan; env_ack_on = a; env_ack_dly = d; env_pend = pend;
      n_cca = 0; n_tx = 0; n_win = 0;
      start = 1; ack_request = ar;
      @(negedge clk);
      start = 0;
      chk("R1", "busy after start", int'(busy), 1);
      chk("R2", "status in progress", int'(status), 7);
      if (l == 7) chk("R6", "tx_start right after start", int'(tx_start), 1);
      cyc = 0;
      while (busy && cyc < 3000) begin
         start = (mid_start && cyc == 1);
         @(negedge clk);
         cyc++;
      end
      start = 0;
      // expected outcome from the requirements
      e_cca = 0; e_tx = 0; e_win = 0; e_st = 5;
      if (l == 7) begin
         e_tx = 1;
         if (!ar) e_st = 0;
         else begin e_win = 1; e_st = (a == 1) ? (pend ? 1 : 0) : 5; end
      end else begin
         for (int k = 1; k <= f + 1; k++) begin
            if (fplan > l) begin e_cca += l + 1; e_st = 3; break; end
            e_cca += fplan + 1;
            e_tx++;
            if (!ar) begin e_st = 0; break; end
            e_win++;
            if (a == k) begin e_st = pend ? 1 : 0; break; end
            if (k == f + 1) e_st = 5;
         end
      end
      rq = (e_st == 3) ? "R7" : (e_st == 5) ? "R5" : ar ? "R4" : "R3";
      if (l == 7) rq = "R6";
      if (mid_start) rq = "R9";
      chk("R1", "busy low at end", int'(busy), 0);
      chk(rq, "status", int'(status), e_st);
      chk(rq, "sends", n_tx, e_tx);
      chk(rq, "access attempts", n_cca, e_cca);
      chk(ar ? "R5" : "R3", "receive windows", n_win, e_win);
      chk("R8", "irq at completion", int'(irq), int'(irq_mask));
      if (do_clear) begin
         irq_clear = 1;
         @(negedge clk);
         irq_clear = 0;
         chk("R8", "irq after clear", int'(irq), 0);
         chk("R8", "status kept after clear", int'(status), e_st);
      end
   endtask

   initial begin
      int cnt = 0;
      repeat (4) @(negedge clk);
      chk("R1", "reset busy", int'(busy), 0);
      chk("R2", "reset status", int'(status), 7);
      chk("R8", "reset irq", int'(irq), 0);
      chk("R7", "reset cca_req", int'(cca_req), 0);
      chk("R4", "reset rx_on", int'(rx_on), 0);
      rst_n = 1;
      @(negedge clk);
      chk("R2", "status idle after reset", int'(status), 7);

      // main sweep
      for (int l = 0; l < 8; l++)
         for (int f = 0; f < 4; f++)
            for (int fs = 0; fs < 3; fs++)
               for (int ar = 0; ar < 2; ar++)
                  for (int as = 0; as < 3; as++) begin
                     int fplan, a;
                     if (ar == 0 && as > 0) continue;
                     fplan = (fs == 0) ? 0 : (fs == 1) ? l : l + 1;
                     a = (as == 0) ? 0 : (as == 1) ? 1 : f + 1;
                     run_txn(l, f, fplan, bit'(ar), a, cnt % WIN, bit'(cnt & 1), 0, 1);
                     cnt++;
                  end

      // R10: acknowledgement in the very last window cycle is accepted
      run_txn(0, 2, 0, 1, 2, WIN - 1, 0, 0, 1);

      // R9: start during a busy transaction is ignored
      run_txn(0, 0, 0, 1, 0, 0, 0, 1, 1);
      run_txn(2, 1, 1, 1, 2, 1, 1, 1, 1);

      // R10: stray acknowledgement while idle changes nothing
      env_stray = 1;
      repeat (3) @(negedge clk);
      chk("R10", "busy after stray ack", int'(busy), 0);
      chk("R10", "status after stray ack", int'(status), 1);
      chk("R10", "irq after stray ack", int'(irq), 0);

      // R8: masked completion, then unmask shows the held flag
      irq_mask = 0;
      run_txn(1, 0, 0, 0, 0, 0, 0, 0, 0);
      chk("R8", "irq masked", int'(irq), 0);
      @(negedge clk);
      irq_mask = 1;
      #1;
      chk("R8", "irq after unmask", int'(irq), 1);
      @(negedge clk);
      irq_clear = 1;
      @(negedge clk);
      irq_clear = 0;
      chk("R8", "irq after clear", int'(irq), 0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule